// File: doc/BRIEF.md
# I2C Slave EEPROM Controller

This block is the serial front end of a 128-byte non-volatile store. It sits on a two-wire I2C bus as a slave. It runs on a fast system clock and oversamples the bus lines. From them it detects START and STOP conditions and bus clock edges. It compares the incoming select byte with a fixed device code and pulls SDA low to acknowledge. The store itself is a register array inside the block.

A write transfer sends a word address and then up to eight data bytes, which collect in a page buffer. When the STOP arrives, the buffered bytes are handed to a simulated self-timed programming cycle, but only if the write-enable input is high at that moment. While that cycle runs, the block ignores its own select code. The array is updated when the cycle ends.

Three kinds of read are supported. A current-address read starts from the internal pointer. A random read first loads the pointer with a dummy write and then issues a repeated START. A sequential read streams bytes for as long as the master keeps acknowledging. A parameter `STRICT_CE` picks the select variant: with it set, bits 3..1 of the select byte must be zero; by default those bits are ignored.

Top module: `i2c_ee_slave`

## Requirements
- R1: The block responds only when bits 7..4 of the select byte (sent MSB first) are 1010. With the default variant, bits 3..1 may take any value. For any other code it gives no acknowledge and does not pull SDA again until the next START.
- R2: The block pulls SDA low during the ninth clock of a matched select byte, of a word-address byte and of every received write-data byte. It changes SDA only after a falling SCL edge, a START or a STOP.
- R3: In a select byte, bit 0 = 0 marks a write and bit 0 = 1 marks a read. After a write select, the next byte is the word address. Its bit 7 is ignored, so address 85h selects location 05h.
- R4: Write-data bytes go to consecutive locations. The low 3 address bits wrap inside the 8-byte page while bits 6..3 stay fixed. A ninth or later byte overwrites the byte sent eight positions earlier.
- R5: Buffered write data reaches the array only if `wr_en_i` is high when the STOP is detected. When it is low, the array keeps its contents. Data bytes are still acknowledged.
- R6: A STOP that commits data starts a busy period of `BUSY_CYCLES` clocks. During this period the select code gets no acknowledge. The data is readable once the period is over.
- R7: A random read is a write select, a word address, a repeated START and a read select. It returns the byte at that address, MSB first.
- R8: During a read, each byte the master acknowledges advances the pointer by one before the next byte is sent. The pointer wraps from 7Fh to 00h.
- R9: When the master does not acknowledge a read byte, the block releases SDA and waits for START or STOP. The pointer does not advance, so a following current-address read returns that same byte again.
- R10: A START that comes before the STOP discards any write data not yet committed.
- R11: After reset SDA is released, the array holds 00h in every location and the pointer is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock as seen on the wire |
| sda_i | input | 1 | Bus data as seen on the wire (wired-AND level) |
| wr_en_i | input | 1 | High lets a STOP commit buffered write data |
| sda_pull_o | output | 1 | High pulls the SDA wire low |

## Verification
The embedded assertions check several rules on every cycle. SDA moves only after an SCL fall, a START or a STOP. The block never acknowledges a select while busy. A programming cycle starts only with write enable high. The page bits stay fixed across data bytes. SDA is released in the wait and master-acknowledge phases. Other behaviours can only be seen in the bench scenarios, by reading data back through the bus: page wrap and overwrite, ignored address bit 7, pointer wrap at 7Fh, repeated-pointer reads after a no-acknowledge, and data discarded by an early START.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;

   localparam int         EE_BYTE_W   = 8;
   localparam logic [3:0] EE_DEV_CODE = 4'b1010;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_DEV,
      ST_DACK,
      ST_ADDR,
      ST_AACK,
      ST_WDAT,
      ST_WACK,
      ST_RDAT,
      ST_RACK,
      ST_WAIT
   } ee_state_e;

endpackage

// File: rtl/i2c_ee_sync.sv
module i2c_ee_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_o,
   output logic scl_rise_o,
   output logic scl_fall_o,
   output logic start_o,
   output logic stop_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("i2c_ee_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] scl_ff, sda_ff;
   logic              scl_p, sda_p;
   logic              scl_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_ff <= '1;
         sda_ff <= '1;
         scl_p  <= 1'b1;
         sda_p  <= 1'b1;
      end else begin
         scl_ff <= {scl_ff[STAGES-2:0], scl_i};
         sda_ff <= {sda_ff[STAGES-2:0], sda_i};
         scl_p  <= scl_s;
         sda_p  <= sda_o;
      end
   end

   assign scl_s      = scl_ff[STAGES-1];
   assign sda_o      = sda_ff[STAGES-1];
   assign scl_rise_o = scl_s & ~scl_p;
   assign scl_fall_o = ~scl_s & scl_p;
   assign start_o    = scl_s & scl_p & ~sda_o & sda_p;
   assign stop_o     = scl_s & scl_p & sda_o & ~sda_p;

endmodule

// File: rtl/i2c_ee_pagebuf.sv
module i2c_ee_pagebuf #(
   parameter int PAGE_W = 3,
   parameter int DW     = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          clr,
   input  logic                          wr,
   input  logic [PAGE_W-1:0]             idx,
   input  logic [DW-1:0]                 wdata,
   output logic [(1<<PAGE_W)*DW-1:0]     data_o,
   output logic [(1<<PAGE_W)-1:0]        mask_o
);

   localparam int SLOTS = 1 << PAGE_W;

   if (PAGE_W < 1) begin : g_bad_page
      $error("i2c_ee_pagebuf: PAGE_W must be at least 1");
   end

   for (genvar g = 0; g < SLOTS; g++) begin : g_slot
      logic [DW-1:0] d_q;
      logic          v_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            d_q <= '0;
            v_q <= 1'b0;
         end else if (clr) begin
            v_q <= 1'b0;
         end else if (wr && idx == PAGE_W'(g)) begin
            d_q <= wdata;
            v_q <= 1'b1;
         end
      end

      assign data_o[g*DW +: DW] = d_q;
      assign mask_o[g]          = v_q;
   end

endmodule

// File: rtl/i2c_ee_busy.sv
module i2c_ee_busy #(
   parameter int CYCLES = 400
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go,
   output logic busy_o,
   output logic done_o
);

   localparam int CW = $clog2(CYCLES + 1);

   if (CYCLES < 1) begin : g_bad_cycles
      $error("i2c_ee_busy: CYCLES must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (go) begin
         cnt_q <= CW'(CYCLES);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign busy_o = (cnt_q != '0);
   assign done_o = (cnt_q == CW'(1));

endmodule

// File: rtl/i2c_ee_array.sv
module i2c_ee_array #(
   parameter int ADDR_W = 7,
   parameter int PAGE_W = 3,
   parameter int DW     = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [ADDR_W-1:0]             rd_addr,
   output logic [DW-1:0]                 rd_data,
   input  logic                          we,
   input  logic [ADDR_W-PAGE_W-1:0]      page,
   input  logic [(1<<PAGE_W)*DW-1:0]     wdata,
   input  logic [(1<<PAGE_W)-1:0]        wmask
);

   localparam int DEPTH  = 1 << ADDR_W;
   localparam int PAGE_N = 1 << PAGE_W;

   if (ADDR_W <= PAGE_W) begin : g_bad_geom
      $error("i2c_ee_array: ADDR_W must exceed PAGE_W");
   end

   logic [DW-1:0] mem_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else if (we) begin
         for (int i = 0; i < PAGE_N; i++) begin
            if (wmask[i]) mem_q[{page, PAGE_W'(i)}] <= wdata[i*DW +: DW];
         end
      end
   end

   assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/i2c_ee_slave.sv
module i2c_ee_slave
   import i2c_ee_pkg::*;
#(
   parameter int ADDR_W      = 7,
   parameter int PAGE_W      = 3,
   parameter int BUSY_CYCLES = 400,
   parameter int SYNC_STAGES = 2,
   parameter bit STRICT_CE   = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   input  logic wr_en_i,
   output logic sda_pull_o
);

   localparam int DW     = EE_BYTE_W;
   localparam int PAGE_N = 1 << PAGE_W;
   localparam int HI_W   = ADDR_W - PAGE_W;

   if (ADDR_W > DW || ADDR_W <= PAGE_W) begin : g_bad_addr
      $error("i2c_ee_slave: need PAGE_W < ADDR_W <= 8");
   end

   // bus conditioning
   logic sda_s, scl_r, scl_f, sta, sto;

   i2c_ee_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl_i),
      .sda_i      (sda_i),
      .sda_o      (sda_s),
      .scl_rise_o (scl_r),
      .scl_fall_o (scl_f),
      .start_o    (sta),
      .stop_o     (sto)
   );

   // state
   ee_state_e         st_q;
   logic [3:0]        cnt_q;
   logic [DW-1:0]     sh_q;
   logic [ADDR_W-1:0] ptr_q;
   logic              rw_q, mack_q, drv_q;

   logic              busy, done, go;
   logic              ce_ok, sel_ok, byte_end;
   logic              pb_wr, pb_clr;
   logic [DW-1:0]     rd_byte;
   logic [ADDR_W-1:0] ptr_next_pg;
   logic [PAGE_N*DW-1:0] pb_data;
   logic [PAGE_N-1:0]    pb_mask;

   // select variant: chip-enable bits ignored or forced to zero
   if (STRICT_CE) begin : g_ce_strict
      assign ce_ok = (sh_q[3:1] == 3'b000);
   end else begin : g_ce_any
      assign ce_ok = 1'b1;
   end

   assign sel_ok      = (sh_q[7:4] == EE_DEV_CODE) && ce_ok && !busy;
   assign byte_end    = scl_f && (cnt_q == 4'd8);
   assign ptr_next_pg = {ptr_q[ADDR_W-1:PAGE_W], ptr_q[PAGE_W-1:0] + 1'b1};

   assign pb_wr  = (st_q == ST_WDAT) && byte_end;
   assign pb_clr = (sta && !busy) || done;
   assign go     = sto && (|pb_mask) && wr_en_i && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         cnt_q  <= '0;
         sh_q   <= '0;
         ptr_q  <= '0;
         rw_q   <= 1'b0;
         mack_q <= 1'b0;
         drv_q  <= 1'b0;
      end else if (sto) begin
         st_q  <= ST_IDLE;
         drv_q <= 1'b0;
      end else if (sta) begin
         st_q  <= ST_DEV;
         cnt_q <= '0;
         drv_q <= 1'b0;
      end else begin
         unique case (st_q)
            ST_DEV, ST_ADDR, ST_WDAT: begin
               if (scl_r) begin
                  sh_q  <= {sh_q[DW-2:0], sda_s};
                  cnt_q <= cnt_q + 4'd1;
               end else if (byte_end) begin
                  cnt_q <= '0;
                  if (st_q == ST_DEV) begin
                     if (sel_ok) begin
                        drv_q <= 1'b1;
                        rw_q  <= sh_q[0];
                        st_q  <= ST_DACK;
                     end else begin
                        st_q  <= ST_WAIT;
                     end
                  end else if (st_q == ST_ADDR) begin
                     drv_q <= 1'b1;
                     ptr_q <= sh_q[ADDR_W-1:0];
                     st_q  <= ST_AACK;
                  end else begin
                     drv_q <= 1'b1;
                     ptr_q <= ptr_next_pg;
                     st_q  <= ST_WACK;
                  end
               end
            end
            ST_DACK: begin
               if (scl_f) begin
                  if (rw_q) begin
                     sh_q  <= rd_byte;
                     drv_q <= ~rd_byte[DW-1];
                     cnt_q <= '0;
                     st_q  <= ST_RDAT;
                  end else begin
                     drv_q <= 1'b0;
                     st_q  <= ST_ADDR;
                  end
               end
            end
            ST_AACK, ST_WACK: begin
               if (scl_f) begin
                  drv_q <= 1'b0;
                  st_q  <= ST_WDAT;
               end
            end
            ST_RDAT: begin
               if (scl_r) begin
                  cnt_q <= cnt_q + 4'd1;
               end else if (scl_f) begin
                  if (cnt_q == 4'd8) begin
                     drv_q <= 1'b0;
                     st_q  <= ST_RACK;
                  end else begin
                     sh_q  <= {sh_q[DW-2:0], 1'b0};
                     drv_q <= ~sh_q[DW-2];
                  end
               end
            end
            ST_RACK: begin
               if (scl_r) begin
                  mack_q <= ~sda_s;
                  if (!sda_s) ptr_q <= ptr_q + 1'b1;
               end else if (scl_f) begin
                  if (mack_q) begin
                     sh_q  <= rd_byte;
                     drv_q <= ~rd_byte[DW-1];
                     cnt_q <= '0;
                     st_q  <= ST_RDAT;
                  end else begin
                     st_q  <= ST_WAIT;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   assign sda_pull_o = drv_q;

   i2c_ee_pagebuf #(.PAGE_W(PAGE_W), .DW(DW)) u_pagebuf (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (pb_clr),
      .wr     (pb_wr),
      .idx    (ptr_q[PAGE_W-1:0]),
      .wdata  (sh_q),
      .data_o (pb_data),
      .mask_o (pb_mask)
   );

   i2c_ee_busy #(.CYCLES(BUSY_CYCLES)) u_busy (
      .clk    (clk),
      .rst_n  (rst_n),
      .go     (go),
      .busy_o (busy),
      .done_o (done)
   );

   i2c_ee_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DW(DW)) u_array (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_addr (ptr_q),
      .rd_data (rd_byte),
      .we      (done),
      .page    (ptr_q[ADDR_W-1:PAGE_W]),
      .wdata   (pb_data),
      .wmask   (pb_mask)
   );

   // checks beside the logic
   AST_SDA_MOVES_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(drv_q) |-> $past(scl_f || sta || sto));                                  // R2
   AST_NO_ACK_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_DACK) |-> !busy);                                                      // R6
   AST_COMMIT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(wr_en_i));                                                   // R5
   AST_PAGE_BITS_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_WACK && $past(st_q) == ST_WDAT) |->
         ptr_q[ADDR_W-1:PAGE_W] == $past(ptr_q[ADDR_W-1:PAGE_W]));                        // R4
   AST_WAIT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_WAIT) |-> !drv_q);                                                     // R9
   AST_MASTER_ACK_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_RACK) |-> !drv_q);                                                     // R9

   logic [HI_W-1:0] unused_hi;
   assign unused_hi = '0;

endmodule

// File: tb/sim_i2c_ee_slave.sv
module sim_i2c_ee_slave;

   localparam int BUSY = 300;
   localparam int Q    = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1;
   logic sda_m = 1'b1;
   logic wr_en = 1'b1;
   logic pull;
   logic sda_line;

   always #4 clk = ~clk;

   assign sda_line = sda_m & ~pull;

   i2c_ee_slave #(.BUSY_CYCLES(BUSY)) u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl),
      .sda_i      (sda_line),
      .wr_en_i    (wr_en),
      .sda_pull_o (pull)
   );

   int          nvec = 0;
   int          nerr = 0;
   bit          ended = 1'b0;
   logic [7:0]  mem_m [128];
   logic [6:0]  ptr_m = '0;
   logic [7:0]  wdat  [16];

   task automatic chk(input string tag, input int act, input int exp);
      nvec++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; tick(Q);
      scl   = 1'b1; tick(Q);
      sda_m = 1'b0; tick(Q);
      scl   = 1'b0; tick(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; tick(Q);
      scl   = 1'b1; tick(Q);
      sda_m = 1'b1; tick(Q);
   endtask

   task automatic put_bit(input bit b);
      sda_m = b; tick(Q);
      scl = 1'b1; tick(Q);
      scl = 1'b0; tick(Q);
   endtask

   task automatic get_bit(output bit b);
      sda_m = 1'b1; tick(Q);
      scl = 1'b1; tick(Q/2);
      b = sda_line; tick(Q/2);
      scl = 1'b0; tick(Q);
   endtask

   task automatic send_byte(input logic [7:0] v, output bit ack);
      bit b;
      for (int i = 7; i >= 0; i--) put_bit(v[i]);
      get_bit(b);
      ack = !b;
   endtask

   task automatic recv_byte(input bit mack, output logic [7:0] v);
      bit b;
      for (int i = 7; i >= 0; i--) begin
         get_bit(b);
         v[i] = b;
      end
      put_bit(!mack);
   endtask

   function automatic logic [6:0] slot(input logic [7:0] a, input int k);
      return {a[6:3], 3'(a[2:0] + k)};
   endfunction

   // write transfer: select, address, n data bytes, STOP; updates model
   task automatic wr_txn(input logic [2:0] ce, input logic [7:0] a, input int n,
                         input bit en, input bit settle);
      bit ak;
      wr_en = en;
      bus_start();
      send_byte({4'hA, ce, 1'b0}, ak); chk("R2 select ack", ak, 1);
      send_byte(a, ak);                chk("R2 address ack", ak, 1);
      for (int k = 0; k < n; k++) begin
         send_byte(wdat[k], ak);       chk("R2 data ack", ak, 1);
      end
      bus_stop();
      if (en && n > 0) begin
         for (int k = 0; k < n; k++) mem_m[slot(a, k)] = wdat[k];
      end
      ptr_m = slot(a, n);
      if (settle) tick((en && n > 0) ? BUSY + 30 : 10);
   endtask

   // read transfer: random (dummy write first) or current address
   task automatic rd_txn(input bit rnd, input logic [7:0] a, input int n, input string tag);
      bit         ak;
      logic [7:0] v;
      bus_start();
      if (rnd) begin
         send_byte(8'hA0, ak); chk("R2 select ack", ak, 1);
         send_byte(a, ak);     chk("R2 address ack", ak, 1);
         bus_start();
         ptr_m = a[6:0];
      end
      send_byte(8'hA1, ak);    chk("R2 read select ack", ak, 1);
      for (int k = 0; k < n; k++) begin
         recv_byte(k < n - 1, v);
         chk(tag, v, mem_m[ptr_m]);
         if (k < n - 1) ptr_m = ptr_m + 1'b1;
      end
      chk("R9 released after no-ack", pull, 0);
      bus_stop();
      tick(6);
   endtask

   initial begin
      repeat (180000) @(posedge clk);
      if (!ended) begin
         nerr++;
         nvec++;
         $display("FAIL watchdog: actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
         $finish;
      end
   end

   initial begin
      bit         ak;
      logic [7:0] a;
      int         n, op;
      for (int i = 0; i < 128; i++) mem_m[i] = 8'h00;
      void'($urandom(32'd20240611));
      tick(5);
      rst_n = 1'b1;
      tick(5);

      // R11: released bus and cleared array after reset
      chk("R11 sda released at reset", pull, 0);
      rd_txn(1'b0, 8'h00, 2, "R11 cleared array via current read");

      // R1: wrong device code is ignored
      bus_start();
      send_byte(8'h92, ak); chk("R1 foreign code not acked", ak, 0);
      send_byte(8'h00, ak); chk("R1 sda left alone after mismatch", ak, 0);
      bus_stop();
      tick(6);

      // R1: chip-enable bits are don't care
      wdat[0] = 8'hC3;
      wr_txn(3'b111, 8'h08, 1, 1'b1, 1'b1);
      rd_txn(1'b1, 8'h08, 1, "R1 select with ce=111 wrote data");

      // R3: address bit 7 ignored
      wdat[0] = 8'h5A;
      wr_txn(3'b000, 8'h85, 1, 1'b1, 1'b1);
      rd_txn(1'b1, 8'h05, 1, "R3 address bit7 dropped");

      // R4: page wrap with full page starting mid-page
      for (int k = 0; k < 8; k++) wdat[k] = 8'(8'h10 + k);
      wr_txn(3'b010, 8'h35, 8, 1'b1, 1'b1);
      rd_txn(1'b1, 8'h30, 8, "R4 page wrap");

      // R4: ten bytes, first two overwritten
      for (int k = 0; k < 10; k++) wdat[k] = 8'(8'hA0 + k);
      wr_txn(3'b000, 8'h10, 10, 1'b1, 1'b1);
      rd_txn(1'b1, 8'h10, 8, "R4 overflow overwrite");

      // R5: write enable low leaves array alone
      for (int k = 0; k < 3; k++) wdat[k] = 8'(8'hE0 + k);
      wr_txn(3'b000, 8'h40, 3, 1'b0, 1'b1);
      rd_txn(1'b1, 8'h40, 3, "R5 gated write unchanged");

      // R6: select refused during busy, data visible afterwards
      wdat[0] = 8'h77; wdat[1] = 8'h88;
      wr_txn(3'b000, 8'h50, 2, 1'b1, 1'b0);
      bus_start();
      send_byte(8'hA1, ak); chk("R6 no ack while busy", ak, 0);
      bus_stop();
      tick(BUSY + 30);
      rd_txn(1'b1, 8'h50, 2, "R6 data after busy");

      // R7: single random read
      rd_txn(1'b1, 8'h37, 1, "R7 random read");

      // R8: sequential read across 7F to 00
      wdat[0] = 8'h7E; wdat[1] = 8'h7F;
      wr_txn(3'b000, 8'h7E, 2, 1'b1, 1'b1);
      wdat[0] = 8'h01; wdat[1] = 8'h02;
      wr_txn(3'b000, 8'h00, 2, 1'b1, 1'b1);
      rd_txn(1'b1, 8'h7E, 4, "R8 sequential wrap");

      // R9: no-ack keeps the pointer
      rd_txn(1'b1, 8'h30, 3, "R9 read before no-ack");
      rd_txn(1'b0, 8'h00, 1, "R9 same byte after no-ack");

      // R10: repeated START discards pending data
      wr_en = 1'b1;
      bus_start();
      send_byte(8'hA0, ak); chk("R2 select ack", ak, 1);
      send_byte(8'h60, ak); chk("R2 address ack", ak, 1);
      send_byte(8'h11, ak); chk("R2 data ack", ak, 1);
      send_byte(8'h22, ak); chk("R2 data ack", ak, 1);
      bus_start();
      bus_stop();
      tick(10);
      rd_txn(1'b1, 8'h60, 2, "R10 discarded data");

      // mixed random traffic
      for (int it = 0; it < 30; it++) begin
         op = $urandom % 3;
         a  = 8'($urandom);
         if (op == 0) begin
            n = 1 + $urandom % 10;
            for (int k = 0; k < n; k++) wdat[k] = 8'($urandom);
            wr_txn(3'($urandom), a, n, ($urandom % 4) != 0, 1'b1);
         end else if (op == 1) begin
            rd_txn(1'b1, a, 1 + $urandom % 5, "R7 random traffic read");
         end else begin
            rd_txn(1'b0, a, 1 + $urandom % 3, "R8 random traffic current read");
         end
      end

      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end

endmodule